// File: doc/BRIEF.md
# Recirculating Self-Sorting Word Store

The block keeps a small set of words in a register array and re-sorts all of them into ascending order on every clock cycle, one cycle being one recirculation pass. Each word is laid out, from most to least significant bit, as a top flag, an address field, a data field and a bottom flag. A word of all ones is empty. Because it is the largest value, empty words gather in the highest slots, and words whose top flag is cleared gather in the lowest slots.

Passes alternate between an accept pass and a resolve pass. In an accept pass, write ports place normal words and request ports place read requests into fixed empty slots at the high end. A request is a word with the wanted address, a zero data field and a cleared bottom flag, so after sorting it sits directly below the word it asks for. In the resolve pass that follows, every request examines the word directly above it. If that word is a normal word, the request claims it and turns into an empty word. Otherwise, the request marks itself for output. A single read port drains the marked words from the lowest slot.

Top module: `sort_store`

## Requirements
- R1: After reset every slot is empty (all ones), `rd_valid` is 0, the first pass is an accept pass and all write and request ports are ready.
- R2: `accept_phase` is 1 in the first pass after reset and inverts on every clock edge after that.
- R3: Write port k is ready exactly when the pass is an accept pass and slot N-1-k is empty. Request port k is ready under the same conditions for slot N-1-NWP-k. An accepted write stores {1, addr, data, 1}. An accepted request stores {1, addr, 0, 0}.
- R4: At every cycle the slots hold their words in ascending unsigned order, with slot 0 lowest.
- R5: In a resolve pass, a request whose upper neighbour is a normal word (top 1, bottom 1, not all ones) claims it. The neighbour becomes {0, addr, data, 1}, and the request becomes all ones. The claimed word therefore has the requested address, or the next higher stored address if the requested address is not present.
- R6: In a resolve pass, a request whose upper neighbour is another request, an empty word or no word at all becomes {0, addr, 0, 0}. After the resolve pass, no request with its top flag set remains.
- R7: Each resolve pass adds exactly as many top-0 words as there were requests.
- R8: `rd_valid` is 1 exactly when slot 0 has its top flag at 0, and `rd_word` shows slot 0. `rd_take` with `rd_valid` high turns that slot back to all ones. `rd_take` with `rd_valid` low changes nothing.
- R9: In a resolve pass, every write and request port is not ready, and words offered on those ports are dropped.
- R10: Words that have been read out or claimed become empty and move to the high end, where they free write and request slots in later accept passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one pass per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | NWP | Write offer, one bit per write port |
| wr_addr | input | NWP*AW | Write address, port k in bits [k*AW +: AW] |
| wr_data | input | NWP*DW | Write data, port k in bits [k*DW +: DW] |
| wr_ready | output | NWP | Write port slot free in an accept pass |
| rq_valid | input | NRP | Read-request offer, one bit per request port |
| rq_addr | input | NRP*AW | Requested address, port k in bits [k*AW +: AW] |
| rq_ready | output | NRP | Request port slot free in an accept pass |
| rd_valid | output | 1 | Slot 0 holds an outgoing word |
| rd_word | output | AW+DW+2 | Contents of slot 0 |
| rd_take | input | 1 | Remove the outgoing word in slot 0 |
| accept_phase | output | 1 | 1 in accept passes, 0 in resolve passes |

## Verification
An ordering fault in the sort or an error in the neighbour pairing shows up on `rd_word` in the first cycle after the resolve pass. The wrong word reaches slot 0, or the words arrive in the wrong order. A slot that is lost or left occupied shows up later. It either changes `wr_ready` and `rq_ready` in the next accept pass or causes a missing or extra outgoing word. A `rd_take` that wrongly erases a normal word becomes visible only when a later request should have claimed that word, so the stimulus sets up exactly that case.

// File: rtl/sort_store_pkg.sv
package sort_store_pkg;
  typedef enum logic {PH_ACCEPT = 1'b0, PH_RESOLVE = 1'b1} phase_e;
endpackage

// File: rtl/sort_store_cmp.sv
// Two-input compare element: lower value on lo, higher on hi.
module sort_store_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic a_le_b;
  assign a_le_b = (a <= b);
  assign lo = a_le_b ? a : b;
  assign hi = a_le_b ? b : a;
endmodule

// File: rtl/sort_store_bitonic.sv
// Full combinational bitonic sorter, ascending, N a power of two.
module sort_store_bitonic #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic [W-1:0] din  [N],
  output logic [W-1:0] dout [N]
);
  localparam int LG = $clog2(N);
  localparam int NL = LG * (LG + 1) / 2;

  logic [W-1:0] st [NL+1][N];

  for (genvar i = 0; i < N; i++) begin : g_in
    assign st[0][i] = din[i];
    assign dout[i]  = st[NL][i];
  end

  for (genvar p = 1; p <= LG; p++) begin : g_blk
    for (genvar q = p - 1; q >= 0; q--) begin : g_lay
      localparam int LY = p * (p - 1) / 2 + (p - 1 - q);
      localparam int J  = 1 << q;
      localparam int K  = 1 << p;
      for (genvar i = 0; i < N; i++) begin : g_pair
        if ((i & J) == 0) begin : g_ce
          localparam int M = i | J;
          logic [W-1:0] lo_w, hi_w;
          sort_store_cmp #(.W(W)) u_cmp (
            .a (st[LY][i]),
            .b (st[LY][M]),
            .lo(lo_w),
            .hi(hi_w)
          );
          if ((i & K) == 0) begin : g_up
            assign st[LY+1][i] = lo_w;
            assign st[LY+1][M] = hi_w;
          end else begin : g_dn
            assign st[LY+1][i] = hi_w;
            assign st[LY+1][M] = lo_w;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sort_store_resolve.sv
// Pairs each request with the word directly above it, all pairs at once.
module sort_store_resolve #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic         en,
  input  logic [W-1:0] din  [N],
  output logic [W-1:0] dout [N],
  output logic [N-1:0] claim_o,
  output logic [N-1:0] self_o
);
  logic [N-1:0] req_w, norm_w, claim_w, self_w, taken_w;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign req_w[i]  = din[i][W-1] & ~din[i][0];
    assign norm_w[i] = din[i][W-1] & din[i][0] & ~(&din[i]);
    if (i < N - 1) begin : g_up
      assign claim_w[i] = req_w[i] & norm_w[i+1];
    end else begin : g_top
      assign claim_w[i] = 1'b0;
    end
    if (i > 0) begin : g_tk
      assign taken_w[i] = claim_w[i-1];
    end else begin : g_tk0
      assign taken_w[i] = 1'b0;
    end
    assign self_w[i] = req_w[i] & ~claim_w[i];
    assign dout[i] = !en                     ? din[i] :
                     claim_w[i]              ? {W{1'b1}} :
                     (self_w[i] | taken_w[i]) ? {1'b0, din[i][W-2:0]} :
                                               din[i];
  end

  assign claim_o = en ? claim_w : '0;
  assign self_o  = en ? self_w  : '0;
endmodule

// File: rtl/sort_store.sv
module sort_store
  import sort_store_pkg::*;
#(
  parameter int N   = 8,
  parameter int AW  = 4,
  parameter int DW  = 8,
  parameter int NWP = 2,
  parameter int NRP = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NWP-1:0]         wr_valid,
  input  logic [NWP*AW-1:0]      wr_addr,
  input  logic [NWP*DW-1:0]      wr_data,
  output logic [NWP-1:0]         wr_ready,
  input  logic [NRP-1:0]         rq_valid,
  input  logic [NRP*AW-1:0]      rq_addr,
  output logic [NRP-1:0]         rq_ready,
  output logic                   rd_valid,
  output logic [AW+DW+1:0]       rd_word,
  input  logic                   rd_take,
  output logic                   accept_phase
);
  localparam int W = AW + DW + 2;

  function automatic logic slot_empty(input logic [W-1:0] w);
    return &w;
  endfunction

  function automatic logic [W-1:0] mk_normal(input logic [AW-1:0] a,
                                             input logic [DW-1:0] d);
    return {1'b1, a, d, 1'b1};
  endfunction

  function automatic logic [W-1:0] mk_request(input logic [AW-1:0] a);
    return {1'b1, a, {DW{1'b0}}, 1'b0};
  endfunction

  phase_e       phase_q;
  logic [W-1:0] mem_q [N];
  logic [W-1:0] res_w [N];
  logic [W-1:0] ins_w [N];
  logic [W-1:0] srt_w [N];
  logic [N-1:0] claim_w, self_w;
  logic [NWP-1:0] wr_take_w;
  logic [NRP-1:0] rq_take_w;
  logic           rd_pop_w;
  logic [N*W-1:0] slot_flat;

  assign accept_phase = (phase_q == PH_ACCEPT);

  for (genvar k = 0; k < NWP; k++) begin : g_wr
    assign wr_ready[k]  = accept_phase & slot_empty(mem_q[N-1-k]);
    assign wr_take_w[k] = wr_valid[k] & wr_ready[k];
  end

  for (genvar k = 0; k < NRP; k++) begin : g_rq
    assign rq_ready[k]  = accept_phase & slot_empty(mem_q[N-1-NWP-k]);
    assign rq_take_w[k] = rq_valid[k] & rq_ready[k];
  end

  assign rd_valid = ~mem_q[0][W-1];
  assign rd_word  = mem_q[0];
  assign rd_pop_w = rd_take & rd_valid;

  for (genvar i = 0; i < N; i++) begin : g_flat
    assign slot_flat[i*W +: W] = mem_q[i];
  end

  sort_store_resolve #(.N(N), .W(W)) u_resolve (
    .en     (!accept_phase),
    .din    (mem_q),
    .dout   (res_w),
    .claim_o(claim_w),
    .self_o (self_w)
  );

  always_comb begin
    ins_w = res_w;
    for (int k = 0; k < NWP; k++) begin
      if (wr_take_w[k]) ins_w[N-1-k] = mk_normal(wr_addr[k*AW +: AW], wr_data[k*DW +: DW]);
    end
    for (int k = 0; k < NRP; k++) begin
      if (rq_take_w[k]) ins_w[N-1-NWP-k] = mk_request(rq_addr[k*AW +: AW]);
    end
    if (rd_pop_w) ins_w[0] = {W{1'b1}};
  end

  sort_store_bitonic #(.N(N), .W(W)) u_sort (
    .din (ins_w),
    .dout(srt_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_ACCEPT;
      for (int i = 0; i < N; i++) mem_q[i] <= {W{1'b1}};
    end else begin
      phase_q <= (phase_q == PH_ACCEPT) ? PH_RESOLVE : PH_ACCEPT;
      for (int i = 0; i < N; i++) mem_q[i] <= srt_w[i];
    end
  end
endmodule

// File: rtl/sort_store_checker.sv
module sort_store_checker #(
  parameter int N   = 8,
  parameter int W   = 14,
  parameter int NWP = 2,
  parameter int NRP = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           accept_phase,
  input logic [NWP-1:0] wr_ready,
  input logic [NRP-1:0] rq_ready,
  input logic           rd_valid,
  input logic           rd_take,
  input logic [N*W-1:0] slot_flat
);
  function automatic int n_out(input logic [N*W-1:0] s);
    int c = 0;
    for (int i = 0; i < N; i++) if (!s[i*W + W - 1]) c++;
    return c;
  endfunction

  function automatic int n_req(input logic [N*W-1:0] s);
    int c = 0;
    for (int i = 0; i < N; i++) if (s[i*W + W - 1] && !s[i*W]) c++;
    return c;
  endfunction

  function automatic logic ordered(input logic [N*W-1:0] s);
    logic ok = 1'b1;
    for (int i = 0; i < N - 1; i++) if (s[i*W +: W] > s[(i+1)*W +: W]) ok = 1'b0;
    return ok;
  endfunction

  assert_phase_flip_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_phase |=> !accept_phase);
  assert_phase_flip_r_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_phase |=> accept_phase);
  assert_slots_ordered_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ordered(slot_flat));
  assert_no_live_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_phase |-> n_req(slot_flat) == 0);
  assert_out_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_phase && !(rd_take && rd_valid)) |=>
      n_out(slot_flat) == $past(n_out(slot_flat)) + $past(n_req(slot_flat)));
  assert_read_pops_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_phase && rd_take && rd_valid) |=>
      n_out(slot_flat) == $past(n_out(slot_flat)) - 1);
  assert_ready_only_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_ready) || (|rq_ready)) |-> accept_phase);
endmodule

bind sort_store sort_store_checker #(.N(N), .W(W), .NWP(NWP), .NRP(NRP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept_phase(accept_phase),
  .wr_ready    (wr_ready),
  .rq_ready    (rq_ready),
  .rd_valid    (rd_valid),
  .rd_take     (rd_take),
  .slot_flat   (slot_flat)
);

// File: tb/sort_store_bench.sv
module sort_store_bench;
  localparam int N = 8, AW = 4, DW = 8, NWP = 2, NRP = 2;
  localparam int W = AW + DW + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NWP-1:0] wr_valid = '0, wr_ready;
  logic [NWP*AW-1:0] wr_addr = '0;
  logic [NWP*DW-1:0] wr_data = '0;
  logic [NRP-1:0] rq_valid = '0, rq_ready;
  logic [NRP*AW-1:0] rq_addr = '0;
  logic rd_valid, rd_take = 1'b0, accept_phase;
  logic [W-1:0] rd_word;

  int checks = 0, fails = 0;
  bit mon_en = 1'b0, force_take = 1'b0, done = 1'b0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] store[$];

  always #5 clk = ~clk;

  sort_store u_sort_store (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .rq_valid(rq_valid), .rq_addr(rq_addr), .rq_ready(rq_ready),
    .rd_valid(rd_valid), .rd_word(rd_word), .rd_take(rd_take),
    .accept_phase(accept_phase)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [W-1:0] w_norm(input logic [AW-1:0] a, input logic [DW-1:0] d);
    return {1'b1, a, d, 1'b1};
  endfunction

  function automatic logic [W-1:0] w_req(input logic [AW-1:0] a);
    return {1'b1, a, {DW{1'b0}}, 1'b0};
  endfunction

  task automatic ins_sorted(ref logic [W-1:0] q[$], input logic [W-1:0] w);
    int pos = q.size();
    for (int i = 0; i < q.size(); i++) if (w < q[i]) begin pos = i; break; end
    q.insert(pos, w);
  endtask

  // Reference: ordered list of stored words plus new requests, each request
  // paired with its upper neighbour in that list.
  task automatic resolve_model(input logic [W-1:0] reqs[$]);
    logic [W-1:0] lst[$];
    bit gone[$];
    foreach (store[i]) ins_sorted(lst, store[i]);
    foreach (reqs[i]) ins_sorted(lst, reqs[i]);
    foreach (lst[i]) gone.push_back(1'b0);
    for (int i = 0; i < lst.size(); i++) begin
      if (!lst[i][0]) begin
        gone[i] = 1'b1;
        if (i + 1 < lst.size() && lst[i+1][0]) begin
          gone[i+1] = 1'b1;
          ins_sorted(exp_q, {1'b0, lst[i+1][W-2:0]});
        end else begin
          ins_sorted(exp_q, {1'b0, lst[i][W-2:0]});
        end
      end
    end
    store = {};
    foreach (lst[i]) if (!gone[i]) store.push_back(lst[i]);
  endtask

  task automatic batch(input int nw, input logic [AW-1:0] wa0, input logic [DW-1:0] wd0,
                       input logic [AW-1:0] wa1, input logic [DW-1:0] wd1,
                       input int nr, input logic [AW-1:0] ra0, input logic [AW-1:0] ra1);
    logic [W-1:0] reqs[$];
    logic [NWP-1:0] ew;
    logic [NRP-1:0] er;
    int occ;
    do @(negedge clk); while (!accept_phase);
    occ = store.size();
    for (int k = 0; k < NWP; k++) ew[k] = (occ <= N - 1 - k);
    for (int k = 0; k < NRP; k++) er[k] = (occ <= N - 1 - NWP - k);
    check(wr_ready == ew, "R3 R10 write readiness", W'(wr_ready), W'(ew));
    check(rq_ready == er, "R3 R10 request readiness", W'(rq_ready), W'(er));
    if (nw > 0) begin wr_valid[0] = 1'b1; wr_addr[0 +: AW] = wa0; wr_data[0 +: DW] = wd0;
      ins_sorted(store, w_norm(wa0, wd0)); end
    if (nw > 1) begin wr_valid[1] = 1'b1; wr_addr[AW +: AW] = wa1; wr_data[DW +: DW] = wd1;
      ins_sorted(store, w_norm(wa1, wd1)); end
    if (nr > 0) begin rq_valid[0] = 1'b1; rq_addr[0 +: AW] = ra0; reqs.push_back(w_req(ra0)); end
    if (nr > 1) begin rq_valid[1] = 1'b1; rq_addr[AW +: AW] = ra1; reqs.push_back(w_req(ra1)); end
    @(negedge clk);
    check(!accept_phase, "R2 resolve pass follows accept", W'(accept_phase), '0);
    wr_valid = '1; wr_addr = {NWP{4'h1}}; wr_data = {NWP{8'h99}};
    rq_valid = '1; rq_addr = '0;
    check(wr_ready == '0 && rq_ready == '0, "R9 ports closed in resolve pass",
          W'({wr_ready, rq_ready}), '0);
    resolve_model(reqs);
    @(negedge clk);
    wr_valid = '0; rq_valid = '0;
    for (int t = 0; t < 20 && exp_q.size() != 0; t++) begin @(negedge clk); #1; end
    check(exp_q.size() == 0, "R7 one output per request", W'(exp_q.size()), '0);
  endtask

  // Monitor: takes every outgoing word and compares with the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && rd_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected output word", rd_word, '0);
        end else begin
          check(rd_word == exp_q[0], "R4 R5 R6 outgoing word", rd_word, exp_q[0]);
          void'(exp_q.pop_front());
        end
        rd_take = 1'b1;
      end else begin
        rd_take = force_take;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(accept_phase == 1'b1, "R1 R2 first pass accepts", W'(accept_phase), 1);
    check(rd_valid == 1'b0, "R1 nothing to read", W'(rd_valid), 0);
    check(wr_ready == '1 && rq_ready == '1, "R1 all ports ready",
          W'({wr_ready, rq_ready}), W'(4'hF));
    mon_en = 1'b1;

    batch(2, 4'd5, 8'h11, 4'd9, 8'h22, 0, 4'd0, 4'd0);
    batch(2, 4'd2, 8'h33, 4'd12, 8'h44, 0, 4'd0, 4'd0);
    // R5: exact match and next-higher match in one pass
    batch(0, 4'd0, 8'h00, 4'd0, 8'h00, 2, 4'd5, 4'd6);
    // R6: two requests for one word; lower one is returned as itself
    batch(0, 4'd0, 8'h00, 4'd0, 8'h00, 2, 4'd12, 4'd12);
    // R6: request with nothing above, alongside a write
    batch(1, 4'd3, 8'h55, 4'd0, 8'h00, 1, 4'd14, 4'd0);

    // R8: rd_take with nothing to read must not erase slot 0
    @(negedge clk); #1 force_take = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(rd_valid == 1'b0, "R8 no outgoing word", W'(rd_valid), 0);
    #1 force_take = 1'b0;
    batch(0, 4'd0, 8'h00, 4'd0, 8'h00, 1, 4'd0, 4'd0);

    // R3 R10: fill the store and watch readiness close slot by slot
    batch(2, 4'd4, 8'h01, 4'd6, 8'h02, 0, 4'd0, 4'd0);
    batch(2, 4'd7, 8'h03, 4'd8, 8'h04, 1, 4'd7, 4'd0);
    batch(2, 4'd10, 8'h05, 4'd11, 8'h06, 0, 4'd0, 4'd0);
    batch(2, 4'd13, 8'h07, 4'd14, 8'h08, 0, 4'd0, 4'd0);
    batch(1, 4'd15, 8'h09, 4'd0, 8'h00, 0, 4'd0, 4'd0);
    batch(0, 4'd0, 8'h00, 4'd0, 8'h00, 0, 4'd0, 4'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule